// File: doc/BRIEF.md
# Debug Serial Command Port

This block lets an external debug controller reach a processor core over a four-wire serial link. The link has a clock driven from outside, a data input, a data output and an active-low request line. All four are asynchronous to the internal clock. The clock, data input and request inputs pass through two-flop synchronizers. The port then decodes everything on the internal clock by finding the edges of the synchronized serial clock.

The controller first holds the request line low. The port raises a halt request to the core. When the core reports that it is in debug mode, the port sends an acknowledge pulse on the data output, and the controller then releases the request line.

After that, the controller shifts in 8-bit commands. Bit 7 selects read (1) or write (0), bit 6 is a resume flag, and bits 5:0 name one of 64 core registers. A write command is followed by a 24-bit word shifted in. A read command fetches the register over a one-cycle bus strobe and shifts the word out, MSB first. Every command ends with an acknowledge pulse. A command with the resume flag set also releases the core from debug mode.

The serial clock half-period must span at least six internal clock cycles.

Top module: `dbg_serial_port`

## Requirements
- R1: After reset the data output is low and the halt request, register read strobe, register write strobe and resume pulse are all low.
- R2: Holding the request input low raises the halt request output within three internal clock cycles, and it stays high while the request is held.
- R3: When the core enters debug mode, the data output goes high for exactly ACK_CYC (default 4) internal clock cycles.
- R4: Serial clock edges arriving while the core is not in debug mode are ignored. They cause no register access, and a command sent after debug mode is entered is decoded from its first bit.
- R5: Command bits are sampled on falling edges of the serial clock, MSB first. Bit 7 is 1 for read and 0 for write, bit 6 is the resume flag, and bits 5:0 are the register address driven on the register bus.
- R6: A write command is followed by 24 data bits, sampled MSB first on falling edges. After the last bit there is exactly one single-cycle write strobe carrying the command's address and that word.
- R7: A read command produces one single-cycle read strobe at the command's address. The word returned is then presented on the data output MSB first, one bit per rising edge of the serial clock, over 24 clocks.
- R8: Each completed command is followed by an acknowledge pulse on the data output that lasts exactly ACK_CYC cycles.
- R9: When the resume flag of a command is set, one single-cycle resume pulse is issued once that command's acknowledge pulse has ended. A command with the flag clear issues no resume pulse.
- R10: Driving the request input low at any time clears a partly received command. The next command is then decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the debug controller, asynchronous |
| ser_din_i | input | 1 | Serial data from the controller |
| dbg_req_n_i | input | 1 | Active-low debug request and resynchronize |
| ser_dout_o | output | 1 | Serial read data and acknowledge pulses |
| halt_req_o | output | 1 | Asks the core to enter debug mode |
| core_halted_i | input | 1 | Core is in debug mode |
| resume_o | output | 1 | Single-cycle pulse releasing the core |
| reg_addr_o | output | 6 | Register bus address |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_wdata_o | output | 24 | Register write data |
| reg_rdata_i | input | 24 | Register read data, sampled in the read-strobe cycle |

## Verification
A change on a serial input acts at the third internal clock edge after it, because of two synchronizer stages plus the edge decode. A read bit therefore appears on the data output three edges after the serial clock rises. The acknowledge pulse starts about five edges after the final falling edge of a command. The bench holds each serial clock phase for eight internal cycles, samples the output just before it lowers the clock, and searches for each acknowledge pulse with a bounded wait before counting its width. Register-bus strobes are compared by a monitor against queued expected items, in whatever cycle they appear.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_RD_FETCH,
      ST_RD_DATA,
      ST_WR_DATA,
      ST_WR_COMMIT,
      ST_DONE,
      ST_ACK_WAIT
   } dbg_state_e;

endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dbg_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbg_ack_gen.sv
module dbg_ack_gen #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic busy_o
);

   localparam int CW = $clog2(CYC + 1);

   if (CYC < 1) begin : g_bad_cyc
      $error("acknowledge length must be at least one cycle");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (trig_i) begin
         cnt_q <= CW'(CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

   // R3
   ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> busy_o);

   // R8
   ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(trig_i));

endmodule

// File: rtl/dbg_shreg.sv
module dbg_shreg #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         shift_i,
   input  logic         ser_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (clr_i) begin
         q_o <= '0;
      end else if (load_i) begin
         q_o <= load_val_i;
      end else if (shift_i) begin
         q_o <= {q_o[W-2:0], ser_i};
      end
   end

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
   import dbg_port_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int ADDR_W      = 6,
   parameter int ACK_CYC     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_din_i,
   input  logic              dbg_req_n_i,
   output logic              ser_dout_o,
   output logic              halt_req_o,
   input  logic              core_halted_i,
   output logic              resume_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              reg_wr_o,
   output logic              reg_rd_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   input  logic [DATA_W-1:0] reg_rdata_i
);

   localparam int CMD_W = ADDR_W + 2;
   localparam int CNT_W = $clog2(DATA_W > CMD_W ? DATA_W : CMD_W);

   if (DATA_W < CMD_W - 1) begin : g_bad_width
      $error("data word must hold a command");
   end

   // synchronized inputs: {request_n, serial clock, serial data}
   logic [2:0] sync_q;
   logic       s_req_n, s_sclk, s_sdi;

   dbg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({dbg_req_n_i, ser_clk_i, ser_din_i}),
      .q_o   (sync_q)
   );

   assign {s_req_n, s_sclk, s_sdi} = sync_q;

   logic sclk_q, halted_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         halted_q <= 1'b0;
      end else begin
         sclk_q   <= s_sclk;
         halted_q <= core_halted_i;
      end
   end

   logic req_act, active, sclk_rise, sclk_fall;
   assign req_act   = ~s_req_n;
   assign active    = core_halted_i & ~req_act;
   assign sclk_rise = s_sclk & ~sclk_q & active;
   assign sclk_fall = ~s_sclk & sclk_q & active;

   dbg_state_e         state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CMD_W-1:0]   cmd_q;
   logic               out_bit_q;
   logic [DATA_W-1:0]  sh_q;
   logic               ack_busy;
   logic               ack_trig;

   logic cmd_rd, cmd_go;
   assign cmd_rd = cmd_q[CMD_W-1];
   assign cmd_go = cmd_q[CMD_W-2];

   logic sh_shift;
   assign sh_shift = (sclk_fall & ((state_q == ST_CMD) | (state_q == ST_WR_DATA)))
                   | (sclk_rise & (state_q == ST_RD_DATA));

   dbg_shreg #(.W(DATA_W)) u_shreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (req_act),
      .load_i     (state_q == ST_RD_FETCH),
      .load_val_i (reg_rdata_i),
      .shift_i    (sh_shift),
      .ser_i      (s_sdi),
      .q_o        (sh_q)
   );

   logic [CMD_W-1:0] cmd_next;
   assign cmd_next = {sh_q[CMD_W-2:0], s_sdi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_CMD;
         cnt_q     <= '0;
         cmd_q     <= '0;
         out_bit_q <= 1'b0;
      end else if (req_act) begin
         state_q   <= ST_CMD;
         cnt_q     <= '0;
         out_bit_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_CMD: begin
               if (sclk_fall) begin
                  if (cnt_q == CNT_W'(CMD_W - 1)) begin
                     cnt_q   <= '0;
                     cmd_q   <= cmd_next;
                     state_q <= cmd_next[CMD_W-1] ? ST_RD_FETCH : ST_WR_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_RD_FETCH: begin
               out_bit_q <= 1'b0;
               state_q   <= ST_RD_DATA;
            end
            ST_RD_DATA: begin
               if (sclk_rise) begin
                  out_bit_q <= sh_q[DATA_W-1];
               end
               if (sclk_fall) begin
                  if (cnt_q == CNT_W'(DATA_W - 1)) begin
                     cnt_q   <= '0;
                     state_q <= ST_DONE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_WR_DATA: begin
               if (sclk_fall) begin
                  if (cnt_q == CNT_W'(DATA_W - 1)) begin
                     cnt_q   <= '0;
                     state_q <= ST_WR_COMMIT;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_WR_COMMIT: state_q <= ST_DONE;
            ST_DONE:      state_q <= ST_ACK_WAIT;
            ST_ACK_WAIT: begin
               if (!ack_busy) begin
                  state_q <= ST_CMD;
               end
            end
            default:      state_q <= ST_CMD;
         endcase
      end
   end

   assign ack_trig = (core_halted_i & ~halted_q) | (state_q == ST_DONE);

   dbg_ack_gen #(.CYC(ACK_CYC)) u_ack (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (ack_trig),
      .busy_o (ack_busy)
   );

   assign ser_dout_o  = ack_busy | ((state_q == ST_RD_DATA) & out_bit_q);
   assign halt_req_o  = req_act;
   assign resume_o    = (state_q == ST_ACK_WAIT) & ~ack_busy & cmd_go & ~req_act;
   assign reg_addr_o  = cmd_q[ADDR_W-1:0];
   assign reg_wr_o    = (state_q == ST_WR_COMMIT);
   assign reg_rd_o    = (state_q == ST_RD_FETCH);
   assign reg_wdata_o = sh_q;

   // R6
   wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> !reg_wr_o);

   // R7
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_o && reg_rd_o));

   // R4
   strobe_in_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_o || reg_rd_o) |-> $past(core_halted_i));

   // R9
   resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |=> !resume_o);

   // R10
   req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req_o |=> (!reg_wr_o && !reg_rd_o && !resume_o));

endmodule

// File: tb/dbg_serial_port_tb.sv
module dbg_serial_port_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HP         = 8;
   localparam int DW         = 24;
   localparam int AW         = 6;
   localparam int ACK        = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sclk = 1'b0, sdi = 1'b0, req_n = 1'b1;
   logic          sdo, halt_req, resume, reg_wr, reg_rd;
   logic          halted;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata, reg_rdata;
   logic [DW-1:0] regfile [64];

   int checks = 0, errors = 0, resume_cnt = 0, wr_cnt = 0, hcnt = 0;
   logic [AW+DW-1:0] wq[$];
   logic [AW-1:0]    rq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_serial_port u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_din_i(sdi),
      .dbg_req_n_i(req_n), .ser_dout_o(sdo), .halt_req_o(halt_req),
      .core_halted_i(halted), .resume_o(resume), .reg_addr_o(reg_addr),
      .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_wdata_o(reg_wdata),
      .reg_rdata_i(reg_rdata)
   );

   assign reg_rdata = regfile[reg_addr];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // core model: halts four cycles after the request, leaves on resume
   always @(posedge clk) begin
      if (!rst_n) begin
         halted <= 1'b0;
         hcnt   <= 0;
      end else if (resume) begin
         halted <= 1'b0;
      end else if (halt_req && !halted) begin
         if (hcnt == 3) begin
            halted <= 1'b1;
            hcnt   <= 0;
         end else begin
            hcnt <= hcnt + 1;
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr) begin
            wr_cnt++;
            if (wq.size() == 0) begin
               chk("R4/R6 unexpected write", {8'h0, reg_addr, reg_wdata}, 32'h0);
            end else begin
               chk("R5/R6 write addr+data", {2'b0, reg_addr, reg_wdata}, {2'b0, wq.pop_front()});
            end
            regfile[reg_addr] <= reg_wdata;
         end
         if (reg_rd) begin
            if (rq.size() == 0) begin
               chk("R4/R7 unexpected read", 32'(reg_addr), 32'hFFFF);
            end else begin
               chk("R5/R7 read addr", 32'(reg_addr), 32'(rq.pop_front()));
            end
         end
         if (resume) resume_cnt++;
      end
   end

   task automatic bit_cycle(input logic din, output logic dout);
      repeat (HP/2) @(negedge clk);
      sdi = din;
      repeat (HP/2) @(negedge clk);
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      dout = sdo;
      sclk = 1'b0;
   endtask

   task automatic send_cmd(input logic rd, input logic go, input logic [AW-1:0] a);
      logic [7:0] c;
      logic       d;
      c = {rd, go, a};
      for (int i = 7; i >= 0; i--) bit_cycle(c[i], d);
   endtask

   task automatic send_word(input logic [DW-1:0] w);
      logic d;
      for (int i = DW-1; i >= 0; i--) bit_cycle(w[i], d);
   endtask

   task automatic recv_word(output logic [DW-1:0] w);
      logic d;
      for (int i = DW-1; i >= 0; i--) begin
         bit_cycle(1'b0, d);
         w[i] = d;
      end
   endtask

   task automatic wait_ack(output int width);
      int t;
      width = 0;
      t = 0;
      while (sdo !== 1'b0 && t < 200) begin @(negedge clk); t++; end
      t = 0;
      while (sdo !== 1'b1 && t < 400) begin @(negedge clk); t++; end
      while (sdo === 1'b1 && width < 100) begin width++; @(negedge clk); end
   endtask

   task automatic enter_debug();
      int w;
      req_n = 1'b0;
      wait_ack(w);
      chk("R3 entry ack width", 32'(w), 32'(ACK));
      req_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) regfile[i] = 24'(i) * 24'h010101;
   end

   initial begin
      repeat (200000) @(negedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int w;
      logic [DW-1:0] d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 dout", 32'(sdo), 32'h0);
      chk("R1 halt_req", 32'(halt_req), 32'h0);
      chk("R1 strobes", {29'h0, reg_wr, reg_rd, resume}, 32'h0);

      // R4: core running, traffic ignored
      send_cmd(1'b0, 1'b0, 6'd3);
      send_word(24'h123456);
      repeat (20) @(negedge clk);
      chk("R4 no write outside debug", 32'(wr_cnt), 32'h0);

      // R2 / R3
      req_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 halt request", 32'(halt_req), 32'h1);
      wait_ack(w);
      chk("R3 entry ack width", 32'(w), 32'(ACK));
      chk("R2 halt request held", 32'(halt_req), 32'h1);
      req_n = 1'b1;
      repeat (10) @(negedge clk);

      // R5/R6/R8 write
      wq.push_back({6'd5, 24'hA5C3F0});
      send_cmd(1'b0, 1'b0, 6'd5);
      send_word(24'hA5C3F0);
      wait_ack(w);
      chk("R8 write ack width", 32'(w), 32'(ACK));
      chk("R6 write issued", 32'(wq.size()), 32'h0);

      // R7 read back
      rq.push_back(6'd5);
      send_cmd(1'b1, 1'b0, 6'd5);
      recv_word(d);
      chk("R7 read data", 32'(d), 32'hA5C3F0);
      wait_ack(w);
      chk("R8 read ack width", 32'(w), 32'(ACK));

      rq.push_back(6'd42);
      send_cmd(1'b1, 1'b0, 6'd42);
      recv_word(d);
      chk("R7 read default", 32'(d), 32'h2A2A2A);
      wait_ack(w);

      // boundary address and data
      wq.push_back({6'd63, 24'h800001});
      send_cmd(1'b0, 1'b0, 6'd63);
      send_word(24'h800001);
      wait_ack(w);
      rq.push_back(6'd63);
      send_cmd(1'b1, 1'b0, 6'd63);
      recv_word(d);
      chk("R7 read addr 63", 32'(d), 32'h800001);
      wait_ack(w);
      chk("R9 no resume without flag", 32'(resume_cnt), 32'h0);

      // R10 resync after partial command
      for (int i = 0; i < 5; i++) bit_cycle(1'b1, d[0]);
      req_n = 1'b0;
      repeat (6) @(negedge clk);
      req_n = 1'b1;
      repeat (6) @(negedge clk);
      wq.push_back({6'd9, 24'h0F0F0F});
      send_cmd(1'b0, 1'b0, 6'd9);
      send_word(24'h0F0F0F);
      wait_ack(w);
      chk("R10 write after resync", 32'(wq.size()), 32'h0);

      // R9 resume
      wq.push_back({6'd10, 24'h555555});
      send_cmd(1'b0, 1'b1, 6'd10);
      send_word(24'h555555);
      wait_ack(w);
      chk("R8 go-command ack width", 32'(w), 32'(ACK));
      repeat (5) @(negedge clk);
      chk("R9 resume pulses", 32'(resume_cnt), 32'h1);
      chk("R9 core left debug", 32'(halted), 32'h0);

      // R4: ignored again, register 11 untouched
      w = wr_cnt;
      send_cmd(1'b0, 1'b0, 6'd11);
      send_word(24'hDEAD01);
      repeat (20) @(negedge clk);
      chk("R4 no write after resume", 32'(wr_cnt), 32'(w));
      enter_debug();
      rq.push_back(6'd11);
      send_cmd(1'b1, 1'b0, 6'd11);
      recv_word(d);
      chk("R4 register 11 unchanged", 32'(d), 32'h0B0B0B);
      wait_ack(w);

      repeat (10) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule